// File: doc/BRIEF.md
# Dual-Clock Synchronous Serial Port

This block moves 8-bit characters over three wires: a serial clock, a transmit line and a receive line. It sends and receives the least-significant bit first. The clock idles low. Transmit data changes after a falling clock edge, and receive data is captured at a rising clock edge. The host loads a character on `tx_byte` and pulses `start`. It then waits for `done` and reads the received character from `rx_byte`.

As clock master, the port makes the serial clock from the peripheral clock. Each half period lasts `div_n + 1` peripheral cycles, so a divider of zero gives the fastest rate, half the peripheral clock. As slave, the port takes the serial clock from an external device on `sclk_in`. That clock passes through a two-flop synchronizer and an edge detector before any bit moves. This makes the port act two to three peripheral cycles after each external edge.

Clearing `tx_enable` gives a receive-only (half-duplex) transfer with the transmit line held high. Setting it gives full duplex: one character goes out while another comes in, over the same eight clocks.

Top module: `sync_serial_port`

## Requirements
- R1: After reset, `sclk_out` is 0, `txd` is 1, `ready` is 1, `done` is 0 and `rx_byte` is 0.
- R2: `sclk_out` is low whenever the port is idle (`ready` = 1), before and after every transfer.
- R3: In master mode, every serial clock period is exactly 2*(`div_n`+1) peripheral cycles, with `div_n` sampled when `start` is accepted.
- R4: The bit sent on `txd` during clock k (k = 0..7) is `tx_byte[k]`. Bit 0 appears when the transfer starts. Later bits change only after a falling serial clock edge.
- R5: The received bits, sampled on the 8 rising edges in order, form `rx_byte` LSB first. `rx_byte` changes only when `done` rises, and that happens at the eighth rising-edge capture.
- R6: In slave mode (`ext_clk_sel` = 1 at start), `sclk_out` stays 0. A change of `sclk_in` made between two peripheral clock edges shows its effect on `txd` after the third rising peripheral edge, and not after the second.
- R7: With `tx_enable` = 0 at start, `txd` stays 1 for the whole transfer, and reception is unaffected.
- R8: A `start` pulse during a transfer is ignored. The character in progress is neither reloaded nor restarted.
- R9: `ready` is 0 from the accepted start until the falling edge after the eighth capture. `done` stays set until the next accepted start clears it.
- R10: In slave mode, `txd` advances on falling `sclk_in` edges, and `rxd` is captured on rising `sclk_in` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk_sel | input | 1 | 1 = slave (external clock), 0 = master; sampled at start |
| tx_enable | input | 1 | 1 = drive characters on txd, 0 = receive only; sampled at start |
| div_n | input | DIVW | Master half-period length minus one, in peripheral cycles |
| start | input | 1 | Begin a transfer when ready |
| tx_byte | input | DW | Character to send, loaded at start |
| ready | output | 1 | Port idle and able to accept start |
| done | output | 1 | Sticky: a character has been received |
| rx_byte | output | DW | Last received character |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_in | input | 1 | External serial clock for slave mode |
| txd | output | 1 | Transmit data, idles high |
| rxd | input | 1 | Receive data |

## Verification
The hardest behaviour to pin down from the ports is the synchronizer latency in slave mode. It depends on where the external edge falls relative to the peripheral clock. The bench changes `sclk_in` halfway between peripheral edges. It then watches `txd` after each of the next three rising peripheral edges, so it sees both that the bit has not moved too early and that it moves on time. To check the ignored start, the bench changes `tx_byte` mid-transfer and pulses `start` again. It then rebuilds the character that actually went out from `txd` samples taken at each rising serial edge.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DW   = 8,
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk_sel,
  input  logic            tx_enable,
  input  logic [DIVW-1:0] div_n,
  input  logic            start,
  input  logic [DW-1:0]   tx_byte,
  output logic            ready,
  output logic            done,
  output logic [DW-1:0]   rx_byte,
  output logic            sclk_out,
  input  logic            sclk_in,
  output logic            txd,
  input  logic            rxd
);
  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_TAIL} st_t;
  st_t st;

  logic            mode_q, txen_q, sclk_q;
  logic [DIVW-1:0] div_q, divc;
  logic [CW-1:0]   bitc;
  logic [DW-1:0]   tx_sh, rx_sh;
  logic [2:0]      sync;

  logic active, m_tick, s_rise, s_fall, rise_stb, fall_stb;

  assign active   = (st != S_IDLE);
  assign m_tick   = active && !mode_q && (divc == div_q);
  assign s_rise   = sync[1] && !sync[2];
  assign s_fall   = !sync[1] && sync[2];
  assign rise_stb = mode_q ? (active && s_rise) : (m_tick && !sclk_q);
  assign fall_stb = mode_q ? (active && s_fall) : (m_tick && sclk_q);

  assign ready    = !active;
  assign sclk_out = sclk_q;
  assign txd      = (active && txen_q) ? tx_sh[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      mode_q  <= 1'b0;
      txen_q  <= 1'b1;
      sclk_q  <= 1'b0;
      div_q   <= '0;
      divc    <= '0;
      bitc    <= '0;
      tx_sh   <= '1;
      rx_sh   <= '0;
      rx_byte <= '0;
      done    <= 1'b0;
    end else begin
      if (active && !mode_q) begin
        divc <= m_tick ? '0 : divc + 1'b1;
        if (m_tick) sclk_q <= !sclk_q;
      end
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SHIFT;
          mode_q <= ext_clk_sel;
          txen_q <= tx_enable;
          div_q  <= div_n;
          divc   <= '0;
          sclk_q <= 1'b0;
          tx_sh  <= tx_byte;
          bitc   <= '0;
          done   <= 1'b0;
        end
        S_SHIFT: begin
          if (rise_stb) begin
            rx_sh <= {rxd, rx_sh[DW-1:1]};
            bitc  <= bitc + 1'b1;
            if (bitc == LAST) begin
              rx_byte <= {rxd, rx_sh[DW-1:1]};
              done    <= 1'b1;
              st      <= S_TAIL;
            end
          end
          if (fall_stb) tx_sh <= {1'b1, tx_sh[DW-1:1]};
        end
        S_TAIL: if (fall_stb) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_clk_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !sclk_out);

  p_tx_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready) && !mode_q && !$stable(txd)) |-> $fell(sclk_out));

  p_rx_on_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> $rose(done));

  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |-> !sclk_out);

  p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !(start && ready)) |=> done);

  p_done_while_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !ready);
endmodule

// File: tb/tb_sync_serial_port.sv
module tb_sync_serial_port;
  logic       clk = 0, rst_n = 0;
  logic       ext_clk_sel = 0, tx_enable = 1, start = 0, sclk_in = 0, rxd = 1;
  logic [7:0] div_n = 0, tx_byte = 0;
  logic       ready, done, sclk_out, txd;
  logic [7:0] rx_byte;
  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sync_serial_port dut (.clk, .rst_n, .ext_clk_sel, .tx_enable, .div_n, .start,
    .tx_byte, .ready, .done, .rx_byte, .sclk_out, .sclk_in, .txd, .rxd);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] b);
    @(negedge clk); tx_byte = b; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic master_xfer(input logic [7:0] n, input logic [7:0] tx, input logic [7:0] rx,
                             input bit ten, input bit poke);
    logic [7:0] got;
    time t0;
    int per;
    bit clk_ok = 1, hi_ok = 1;
    ext_clk_sel = 0; tx_enable = ten; div_n = n; rxd = rx[0];
    pulse_start(tx);
    chk(ready == 0, "R9 ready low in transfer", ready, 0);
    chk(done == 0, "R9 done cleared by start", done, 0);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk_out);
      got[i] = txd;
      if (!txd) hi_ok = 0;
      if (i == 1) per = int'(($time - t0) / 8);
      if (i > 1 && ($time - t0) != time'(2 * (n + 1) * 8)) clk_ok = 0;
      t0 = $time;
      if (poke && i == 3) begin
        @(negedge clk); tx_byte = ~tx; start = 1;
        @(negedge clk); start = 0;
      end
      @(negedge sclk_out);
      if (i < 7) rxd = rx[i+1];
    end
    @(negedge clk);
    chk(per == 2 * (n + 1) && clk_ok, "R3 master clock period", per, 2 * (n + 1));
    if (ten) chk(got == tx, poke ? "R8 busy start ignored" : "R4 LSB-first transmit", got, tx);
    else     chk(hi_ok, "R7 txd high in receive-only", got, 8'hff);
    chk(rx_byte == rx, "R5 received byte", rx_byte, rx);
    chk(ready && !sclk_out && txd, "R2 idle clock low and txd high", {ready, sclk_out, txd}, 3'b101);
    repeat (3) @(negedge clk);
    chk(done == 1, "R9 done sticky", done, 1);
  endtask

  task automatic slave_xfer(input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] got;
    bit quiet = 1;
    ext_clk_sel = 1; tx_enable = 1; sclk_in = 0; rxd = rx[0];
    pulse_start(tx);
    for (int i = 0; i < 8; i++) begin
      repeat (5) begin @(negedge clk); if (sclk_out) quiet = 0; end
      got[i] = txd;
      sclk_in = 1;
      repeat (5) begin @(negedge clk); if (sclk_out) quiet = 0; end
      if (i == 7) begin
        chk(done == 1 && rx_byte == rx, "R10 capture on sclk_in rise", rx_byte, rx);
        chk(ready == 0, "R9 busy until final fall", ready, 0);
      end
      sclk_in = 0;
      if (i < 7) rxd = rx[i+1];
      if (i == 0) begin
        repeat (2) @(posedge clk);
        #1 chk(txd == tx[0], "R6 no shift after two edges", txd, tx[0]);
        @(posedge clk);
        #1 chk(txd == tx[1], "R6 shift after third edge", txd, tx[1]);
        @(negedge clk);
      end
    end
    repeat (5) @(negedge clk);
    chk(got == tx, "R10 slave transmit order", got, tx);
    chk(quiet, "R6 sclk_out quiet in slave mode", quiet, 1);
    chk(ready && txd, "R2 slave back to idle", {ready, txd}, 2'b11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_out == 0 && txd == 1 && ready == 1 && done == 0 && rx_byte == 0,
        "R1 reset state", {sclk_out, txd, ready, done, rx_byte}, 12'h600);
    rst_n = 1;
    repeat (2) @(negedge clk);
    master_xfer(8'd0, 8'hA5, 8'h3C, 1, 0);
    master_xfer(8'd3, 8'h81, 8'hE7, 1, 0);
    master_xfer(8'd1, 8'h5A, 8'h96, 0, 0);
    master_xfer(8'd2, 8'hC3, 8'h0F, 1, 1);
    slave_xfer(8'h6D, 8'hB2);
    slave_xfer(8'h12, 8'h7E);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule